// File: doc/BRIEF.md
# Clipped-Mean Adaptive Noise Threshold

This block keeps a running noise figure for every channel of a time-multiplexed stream of smoothed energy samples, and marks samples that rise well above that figure as putative spikes. Samples arrive one per cycle at most. Each carries a channel index, so the channels may come in any order and with idle cycles in between. Each channel collects a window of 64 samples. When the window closes, the sum is divided by 64 and scaled by a correction factor, which gives the channel's noise estimate.

Within a channel, the estimate is winsorized. During the first window, nothing has been estimated yet, so samples are summed as they arrive and the result is scaled by 80/64. In every later window, a sample larger than the current estimate is replaced by the estimate before it is summed, and the result is scaled by 101/64. Large spikes therefore cannot inflate the noise figure. The detection threshold is the estimate multiplied by a constant, 5 by default.

Each channel's state is one of two phases. `PH_LEARN` is the first window and `PH_TRACK` covers every later window. The transition `LEARN_DONE` moves from `PH_LEARN` to `PH_TRACK` when the first window closes. The transition `TRACK_ROLL` keeps the channel in `PH_TRACK` as each later window closes. Reset places every channel in `PH_LEARN`.

Top module: `clipped_noise_thresh`

## Requirements
- R1: Each channel has its own window count, sum, estimate and phase, and a sample changes only the state of the channel given by its index.
- R2: In the first window of a channel, the 64 samples are summed without clipping. At the 64th sample the estimate becomes floor(floor(sum/64)*80/64).
- R3: In every later window, a sample strictly greater than the current estimate is summed as the estimate. At the 64th sample the estimate becomes floor(floor(sum/64)*101/64).
- R4: A channel's estimate changes only when its window closes. The sum restarts at zero, so the next window's first sample opens a fresh sum.
- R5: For each accepted sample, out_threshold equals THR_MULT times the estimate in force when the sample arrived, that is before any update that sample causes. It is 0 while the channel is in its first window.
- R6: out_spike is 1 exactly when the channel has completed its first window and the sample is strictly greater than out_threshold.
- R7: The outputs for a sample appear on the cycle after the sample is accepted, with out_valid high and out_ch equal to the sample's index. out_valid is low after a cycle with no input. Reset returns every channel to the first window with a zero estimate.
- R8: Full-scale samples (all 20 bits set) are summed over a whole window without overflow, so the estimates follow R2 and R3 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | CH_W | Channel index of the sample |
| in_energy | input | DATA_W (20) | Unsigned smoothed energy sample |
| out_valid | output | 1 | Result present this cycle |
| out_ch | output | CH_W | Channel index of the result |
| out_threshold | output | THR_W (24) | Detection threshold applied to the sample |
| out_spike | output | 1 | Sample exceeded the threshold |

## Verification
The bench sends samples on channel 0 exactly at the threshold and one above it. If the design used the wrong comparison, it would flag the equal sample or miss the larger one. Spikes placed in a learning window must be summed in full, and spikes placed in a tracking window must be clipped. A design that clipped during learning, or failed to clip afterwards, would then produce a wrong estimate in the next window. Channel order is shuffled and idle cycles are inserted, so state leaking between channels or an estimate updated mid-window would show up as wrong thresholds. A full-scale channel exposes a sum that is too narrow, and the first sample after each window boundary exposes a sum that was not cleared.

// File: rtl/clipped_noise_thresh_pkg.sv
package clipped_noise_thresh_pkg;
    typedef enum logic {
        PH_LEARN = 1'b0,
        PH_TRACK = 1'b1
    } ch_phase_e;
endpackage

// File: rtl/cnt_chan_bank.sv
module cnt_chan_bank
    import clipped_noise_thresh_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 6,
    parameter int ACC_W  = 26,
    parameter int EST_W  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  rd_ch,
    output ch_phase_e        rd_phase,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [ACC_W-1:0] rd_acc,
    output logic [EST_W-1:0] rd_est,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  ch_phase_e        wr_phase,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [ACC_W-1:0] wr_acc,
    input  logic [EST_W-1:0] wr_est
);
    ch_phase_e        phase_q [NUM_CH];
    logic [CNT_W-1:0] cnt_q   [NUM_CH];
    logic [ACC_W-1:0] acc_q   [NUM_CH];
    logic [EST_W-1:0] est_q   [NUM_CH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                phase_q[i] <= PH_LEARN;
                cnt_q[i]   <= '0;
                acc_q[i]   <= '0;
                est_q[i]   <= '0;
            end
        end else if (wr_en) begin
            phase_q[wr_ch] <= wr_phase;
            cnt_q[wr_ch]   <= wr_cnt;
            acc_q[wr_ch]   <= wr_acc;
            est_q[wr_ch]   <= wr_est;
        end
    end

    assign rd_phase = phase_q[rd_ch];
    assign rd_cnt   = cnt_q[rd_ch];
    assign rd_acc   = acc_q[rd_ch];
    assign rd_est   = est_q[rd_ch];
endmodule

// File: rtl/cnt_winsor_math.sv
module cnt_winsor_math
    import clipped_noise_thresh_pkg::*;
#(
    parameter int DATA_W     = 20,
    parameter int WIN_LOG2   = 6,
    parameter int FRAC_BITS  = 6,
    parameter int FACT_FIRST = 80,
    parameter int FACT_LATER = 101,
    parameter int ACC_W      = 26,
    parameter int EST_W      = 21
) (
    input  ch_phase_e         phase,
    input  logic [DATA_W-1:0] sample,
    input  logic [ACC_W-1:0]  acc,
    input  logic [EST_W-1:0]  est,
    output logic [ACC_W-1:0]  sum_next,
    output logic [EST_W-1:0]  est_from_sum
);
    localparam int FACT_W = $clog2(FACT_LATER + 1);
    localparam int MEAN_W = ACC_W - WIN_LOG2;
    localparam int PROD_W = MEAN_W + FACT_W;

    logic [DATA_W-1:0] clip_val;
    logic [MEAN_W-1:0] mean;
    logic [FACT_W-1:0] factor;
    logic [PROD_W-1:0] prod;

    always_comb begin
        unique case (phase)
            PH_LEARN: begin
                clip_val = sample;
                factor   = FACT_W'(FACT_FIRST);
            end
            PH_TRACK: begin
                clip_val = ({1'b0, sample} > EST_W'(est)) ? DATA_W'(est) : sample;
                factor   = FACT_W'(FACT_LATER);
            end
            default: begin
                clip_val = sample;
                factor   = FACT_W'(FACT_FIRST);
            end
        endcase
        sum_next     = acc + ACC_W'(clip_val);
        mean         = sum_next[ACC_W-1:WIN_LOG2];
        prod         = PROD_W'(mean) * PROD_W'(factor);
        est_from_sum = EST_W'(prod >> FRAC_BITS);
    end
endmodule

// File: rtl/clipped_noise_thresh.sv
module clipped_noise_thresh
    import clipped_noise_thresh_pkg::*;
#(
    parameter int NUM_CH     = 32,
    parameter int DATA_W     = 20,
    parameter int WIN_LOG2   = 6,
    parameter int THR_MULT   = 5,
    parameter int FACT_FIRST = 80,
    parameter int FACT_LATER = 101,
    parameter int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int THR_W      = DATA_W + 1 + $clog2(THR_MULT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [DATA_W-1:0] in_energy,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_ch,
    output logic [THR_W-1:0]  out_threshold,
    output logic              out_spike
);
    localparam int CNT_W     = WIN_LOG2;
    localparam int ACC_W     = DATA_W + WIN_LOG2;
    localparam int EST_W     = DATA_W + 1;
    localparam int FRAC_BITS = 6;

    ch_phase_e        cur_phase, nxt_phase;
    logic [CNT_W-1:0] cur_cnt, nxt_cnt;
    logic [ACC_W-1:0] cur_acc, nxt_acc, sum_next;
    logic [EST_W-1:0] cur_est, nxt_est, est_from_sum;
    logic             win_done;
    logic [THR_W-1:0] cur_thr;
    logic             cur_spike;

    cnt_chan_bank #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .EST_W(EST_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .rd_ch(in_ch), .rd_phase(cur_phase), .rd_cnt(cur_cnt),
        .rd_acc(cur_acc), .rd_est(cur_est),
        .wr_en(in_valid), .wr_ch(in_ch), .wr_phase(nxt_phase),
        .wr_cnt(nxt_cnt), .wr_acc(nxt_acc), .wr_est(nxt_est)
    );

    cnt_winsor_math #(
        .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .FRAC_BITS(FRAC_BITS),
        .FACT_FIRST(FACT_FIRST), .FACT_LATER(FACT_LATER),
        .ACC_W(ACC_W), .EST_W(EST_W)
    ) math_i (
        .phase(cur_phase), .sample(in_energy), .acc(cur_acc), .est(cur_est),
        .sum_next(sum_next), .est_from_sum(est_from_sum)
    );

    // Next-state logic for the channel addressed this cycle
    always_comb begin
        win_done  = (cur_cnt == {CNT_W{1'b1}});
        nxt_cnt   = cur_cnt + 1'b1;
        nxt_acc   = win_done ? '0 : sum_next;
        nxt_est   = win_done ? est_from_sum : cur_est;
        nxt_phase = cur_phase;
        cur_thr   = '0;
        cur_spike = 1'b0;
        unique case (cur_phase)
            PH_LEARN: begin
                if (win_done) nxt_phase = PH_TRACK;   // LEARN_DONE
            end
            PH_TRACK: begin
                nxt_phase = PH_TRACK;                 // TRACK_ROLL
                cur_thr   = THR_W'(cur_est) * THR_W'(THR_MULT);
                cur_spike = THR_W'(in_energy) > cur_thr;
            end
            default: nxt_phase = PH_LEARN;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_ch        <= '0;
            out_threshold <= '0;
            out_spike     <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_ch        <= in_valid ? in_ch : out_ch;
            out_threshold <= in_valid ? cur_thr : out_threshold;
            out_spike     <= in_valid & cur_spike;
        end
    end
endmodule

// File: rtl/clipped_noise_thresh_chk.sv
module clipped_noise_thresh_chk #(
    parameter int CH_W   = 5,
    parameter int DATA_W = 20,
    parameter int THR_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CH_W-1:0]   in_ch,
    input logic [DATA_W-1:0] in_energy,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_ch,
    input logic [THR_W-1:0]  out_threshold,
    input logic              out_spike
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R7
    AST_CH_ECHO: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_ch == $past(in_ch)); // R7
    AST_SPIKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) out_spike |-> out_valid); // R6
    AST_SPIKE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_spike || (THR_W'($past(in_energy)) > out_threshold))); // R6
endmodule

bind clipped_noise_thresh clipped_noise_thresh_chk #(
    .CH_W(CH_W), .DATA_W(DATA_W), .THR_W(THR_W)
) chk_i (.*);

// File: tb/clipped_noise_thresh_tb.sv
module clipped_noise_thresh_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 4;
    localparam int CHW    = 2;
    localparam int DW     = 20;
    localparam int TW     = 24;
    localparam int MAXCYC = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CHW-1:0] in_ch = '0;
    logic [DW-1:0] in_energy = '0;
    logic          out_valid;
    logic [CHW-1:0] out_ch;
    logic [TW-1:0] out_threshold;
    logic          out_spike;

    always #(CLK_PERIOD/2) clk = ~clk;

    clipped_noise_thresh #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
        .in_energy(in_energy), .out_valid(out_valid), .out_ch(out_ch),
        .out_threshold(out_threshold), .out_spike(out_spike)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference
    longint m_est [NCH];
    longint m_acc [NCH];
    int     m_cnt [NCH];
    int     m_win [NCH];
    bit     exp_v = 0;
    int     exp_ch = 0;
    longint exp_thr = 0;
    bit     exp_sp = 0;
    string  exp_tag = "R7";
    logic [31:0] lf = 32'h1234_5678;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R7 out_valid", longint'(out_valid), longint'(exp_v));
        if (exp_v) begin
            chk("R1 R7 out_ch", longint'(out_ch), longint'(exp_ch));
            chk({exp_tag, " threshold"}, longint'(out_threshold), exp_thr);
            chk("R6 spike", longint'(out_spike), longint'(exp_sp));
        end
    endtask

    // one clock: check previous result, then drive
    task automatic step(input bit v, input int ch, input longint val);
        longint clipped;
        @(negedge clk);
        compare();
        in_valid  = v;
        in_ch     = CHW'(ch);
        in_energy = DW'(val);
        exp_v = v;
        if (v) begin
            exp_ch  = ch;
            exp_thr = (m_win[ch] > 0) ? m_est[ch] * 5 : 0;
            exp_sp  = (m_win[ch] > 0) && (val > exp_thr);
            if (ch == 3) exp_tag = "R8";
            else if (m_win[ch] > 0 && m_cnt[ch] == 0) exp_tag = "R4";
            else if (m_win[ch] == 0) exp_tag = "R5";
            else if (m_win[ch] == 1) exp_tag = "R2";
            else exp_tag = "R3";
            clipped = (m_win[ch] > 0 && val > m_est[ch]) ? m_est[ch] : val;
            m_acc[ch] += clipped;
            m_cnt[ch]++;
            if (m_cnt[ch] == 64) begin
                m_est[ch] = ((m_acc[ch] / 64) * ((m_win[ch] == 0) ? 80 : 101)) / 64;
                m_acc[ch] = 0;
                m_cnt[ch] = 0;
                m_win[ch]++;
            end
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_est[c] = 0; m_acc[c] = 0; m_cnt[c] = 0; m_win[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state (R7)
        chk("R7 reset out_valid", longint'(out_valid), 0);
        chk("R7 reset threshold", longint'(out_threshold), 0);
        rst_n = 1'b1;
        // window 1: learning, unclipped spikes on ch2 (R2), full scale on ch3 (R8)
        for (int i = 0; i < 64; i++) begin
            step(1, 0, 1000);
            step(1, 1, 200 + i * 7);
            step(1, 2, (i % 16 == 5) ? 500000 : 3000);
            step(1, 3, 20'hFFFFF);
            if (i % 9 == 0) step(0, 0, 0);
        end
        // window 2: boundary on ch0 (threshold 6250), clipped spikes on ch2 (R3)
        for (int i = 0; i < 64; i++) begin
            if (i == 3) step(1, 0, 6250);
            else if (i == 4) step(1, 0, 6251);
            else step(1, 0, 900 + (i % 5) * 100);
            step(1, 2, (i % 8 == 1) ? 400000 : 2500);
            step(1, 3, 20'hFFFFF);
            step(1, 1, 150 + i);
        end
        // shuffled order, random values with occasional spikes (R1, R3, R4)
        for (int i = 0; i < 900; i++) begin
            int ch;
            longint v;
            lf = nxt(lf);
            ch = int'(lf[1:0]);
            v  = (lf[9:4] == 0) ? longint'(lf[27:8]) : longint'(lf[21:10]);
            if (ch == 3) v = 20'hFFFFF - longint'(lf[5:0]);
            step(lf[30:28] != 0, ch, v);
        end
        step(0, 0, 0);
        step(0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        while (cycles < MAXCYC) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, MAXCYC);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule